// File: doc/BRIEF.md
# Windowed Watchdog with Post-Arm Lockout

This block watches a periodic strobe from supervising software and checks that each strobe lands inside a fixed time window after the one before it. A strobe that comes too soon, or no strobe before the late limit, is a violation. Every violation drives an active-low interrupt. Time is counted in milliseconds: a prescaler turns the clock into a millisecond tick, and the window bounds are set in ticks.

The block has two phases. After power-on reset it is unarmed. In that phase software can deliberately strobe early, strobe late and strobe on time, and read the interrupt each time. This tests the watchdog without latching it. Software then arms the block by issuing a strobe while `arm_i` is high.

Once armed, the first violation locks the block until the next power-on reset. In that state the interrupt stays asserted, the timer freezes, later strobes are ignored, the fault lamp output turns on and the drive-inhibit output goes low.

Top module: `window_watchdog`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released, `wdt_irq_no` is 1, `fault_lamp_o` is 0, `drive_inhibit_no` is 1, and the block is unarmed.
- R2: `strobe_i` passes through a two-stage synchronizer and a rising-edge detector. A high pulse of any width counts as one strobe. Its result appears at the ports after the third rising clock edge that follows the input rising.
- R3: A strobe whose gap to the previous accepted strobe is less than EARLY_MS*TICK_DIV clock cycles is early. It drives `wdt_irq_no` to 0.
- R4: If no strobe arrives, `wdt_irq_no` falls to 0 after the edge that lies exactly LATE_MS*TICK_DIV cycles after the last accepted strobe. It is still 1 one cycle earlier.
- R5: The gap is measured between the rising edges of `strobe_i`. A gap of exactly EARLY_MS*TICK_DIV cycles is in the window. A gap of exactly LATE_MS*TICK_DIV cycles is late.
- R6: A strobe whose gap lies in [EARLY_MS*TICK_DIV, LATE_MS*TICK_DIV) is on time. In the unarmed phase it returns `wdt_irq_no` to 1. Every accepted strobe, early ones included, restarts the timing.
- R7: In the unarmed phase violations never latch. `fault_lamp_o` stays 0, and a later on-time strobe releases the interrupt.
- R8: A strobe accepted while `arm_i` is 1 in the unarmed phase arms the block, restarts the timing and sets `wdt_irq_no` to 1, whatever its gap. A high level on `arm_i` without a strobe does nothing.
- R9: In the armed phase, an early strobe or a timeout locks the block. From then on `wdt_irq_no` is 0, `fault_lamp_o` is 1 and `drive_inhibit_no` is 0.
- R10: Once locked, the timer holds its state and every later strobe is ignored. The outputs do not change until reset.
- R11: Only `rst_ni` releases the lock. It also returns the block to the unarmed phase, where violations again do not latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| strobe_i | input | 1 | Asynchronous watchdog strobe from software |
| arm_i | input | 1 | Arm request, sampled together with an accepted strobe |
| wdt_irq_no | output | 1 | Active-low watchdog interrupt |
| fault_lamp_o | output | 1 | High when a fault has latched (lamp on) |
| drive_inhibit_no | output | 1 | Low when a fault has latched, cutting output drive |

## Verification
A wrong internal state shows at the ports quickly.

- **Prescaler or millisecond count off by one:** a strobe at exactly the early or late boundary flips the interrupt the wrong way. The error shows three edges after that strobe rises, and it also moves the falling edge of the timeout by one cycle.
- **Enable flag wrong:** either an unarmed violation lights the lamp at once, or an armed violation leaves the lamp dark.
- **Lock state that leaks:** the interrupt returns high after a later strobe, or after a long idle stretch.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_OK    = 2'd1,
    VERD_EARLY = 2'd2,
    VERD_LATE  = 2'd3
  } verdict_e;
endpackage

// File: rtl/wdw_strobe_edge.sv
module wdw_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic pulse_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= strobe_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];

  assign pulse_o = sync_q[LAST] & ~prev_q;

  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/wdw_window_timer.sv
module wdw_window_timer
  import wdw_pkg::*;
#(
  parameter int TICK_DIV = 200000,
  parameter int EARLY_MS = 10,
  parameter int LATE_MS  = 15
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     strobe_i,
  input  logic     freeze_i,
  output verdict_e verdict_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MS_W  = $clog2(LATE_MS + 1);
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(TICK_DIV - 1);
  localparam logic [MS_W-1:0]  MS_EARLY = MS_W'(EARLY_MS);
  localparam logic [MS_W-1:0]  MS_LATE  = MS_W'(LATE_MS);

  logic [DIV_W-1:0] div_q;
  logic [MS_W-1:0]  ms_q, ms_next;
  logic             tick, expired;

  assign tick    = (div_q == DIV_TOP);
  assign expired = (ms_q == MS_LATE);
  // ms count including the current cycle, so a gap of N*TICK_DIV reads N
  assign ms_next = expired ? ms_q : ms_q + MS_W'(tick);

  always_comb begin
    verdict_o = VERD_NONE;
    if (!freeze_i) begin
      if (strobe_i) begin
        if (ms_next < MS_EARLY)      verdict_o = VERD_EARLY;
        else if (ms_next >= MS_LATE) verdict_o = VERD_LATE;
        else                         verdict_o = VERD_OK;
      end else if (!expired && ms_next == MS_LATE) begin
        verdict_o = VERD_LATE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ms_q  <= '0;
    end else if (!freeze_i) begin
      if (strobe_i) begin
        div_q <= '0;
        ms_q  <= '0;
      end else if (!expired) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        ms_q  <= ms_next;
      end
    end
  end

  assert_frozen_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> ($stable(ms_q) && $stable(div_q)));
  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !freeze_i) |=> (ms_q == '0 && div_q == '0));
  assert_timeout_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == VERD_LATE && !strobe_i) |=> expired);
endmodule

// File: rtl/wdw_lockout.sv
module wdw_lockout
  import wdw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     stb_i,
  input  logic     arm_i,
  input  verdict_e verdict_i,
  output logic     enable_o,
  output logic     locked_o,
  output logic     irq_o
);
  logic enable_q, locked_q, irq_q;
  logic arming;

  assign arming = stb_i && arm_i && !enable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      locked_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (!locked_q) begin
      if (arming) begin
        enable_q <= 1'b1;
        irq_q    <= 1'b0;
      end else begin
        case (verdict_i)
          VERD_OK: irq_q <= 1'b0;
          VERD_EARLY, VERD_LATE: begin
            irq_q <= 1'b1;
            if (enable_q) locked_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign enable_o = enable_q;
  assign locked_o = locked_q;
  assign irq_o    = irq_q | locked_q;

  assert_unarmed_no_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_q |-> !locked_q);
  assert_lock_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> (locked_q && irq_o));
  assert_early_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_i == VERD_EARLY && !locked_q && !arming) |=> irq_o);
  assert_arm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arming && !locked_q) |=> (enable_q && !irq_o));
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdw_pkg::*;
#(
  parameter int TICK_DIV    = 200000,
  parameter int EARLY_MS    = 10,
  parameter int LATE_MS     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic arm_i,
  output logic wdt_irq_no,
  output logic fault_lamp_o,
  output logic drive_inhibit_no
);
  logic     stb_pulse, stb_accept;
  logic     enable, locked, irq;
  verdict_e verdict;

  wdw_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .pulse_o (stb_pulse)
  );

  assign stb_accept = stb_pulse & ~locked;

  wdw_window_timer #(
    .TICK_DIV(TICK_DIV),
    .EARLY_MS(EARLY_MS),
    .LATE_MS (LATE_MS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (stb_accept),
    .freeze_i (locked),
    .verdict_o(verdict)
  );

  wdw_lockout u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (stb_accept),
    .arm_i    (arm_i),
    .verdict_i(verdict),
    .enable_o (enable),
    .locked_o (locked),
    .irq_o    (irq)
  );

  assign wdt_irq_no       = ~irq;
  assign fault_lamp_o     = locked;
  assign drive_inhibit_no = ~locked;

  assert_ignore_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && stb_pulse) |=> (!wdt_irq_no && fault_lamp_o && !drive_inhibit_no));
  assert_lock_needs_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked) |-> $past(enable));
endmodule

// File: tb/window_watchdog_bench.sv
`timescale 1ns/1ps
module window_watchdog_bench;
  localparam int DIV   = 8;
  localparam int EARLY = 10 * DIV;
  localparam int LATE  = 15 * DIV;
  localparam int VN    = 11;
  localparam int VGAP [VN] = '{100, 40, 100, 80, 79, 119, 120, 150, 90, 10, 85};
  localparam bit VEXP [VN] = '{1,   0,  1,   1,  0,  1,   0,   0,   1,  0,  1};

  logic clk_i = 1'b0, rst_ni = 1'b0, strobe_i = 1'b0, arm_i = 1'b0;
  logic wdt_irq_no, fault_lamp_o, drive_inhibit_no;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  window_watchdog #(.TICK_DIV(DIV), .EARLY_MS(10), .LATE_MS(15)) u_window_watchdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .arm_i(arm_i),
    .wdt_irq_no(wdt_irq_no), .fault_lamp_o(fault_lamp_o),
    .drive_inhibit_no(drive_inhibit_no)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // raise at a negedge, sample three edges later (result of this strobe)
  task automatic pulse(input logic arm);
    arm_i = arm; strobe_i = 1'b1;
    repeat (3) @(negedge clk_i);
    strobe_i = 1'b0; arm_i = 1'b0;
  endtask

  task automatic gap_pulse(input int gap, input logic arm);
    repeat (gap - 3) @(negedge clk_i);
    pulse(arm);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 irq in reset", wdt_irq_no, 1'b1);
    chk("R1 lamp in reset", fault_lamp_o, 1'b0);
    chk("R1 inhibit in reset", drive_inhibit_no, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 irq after release", wdt_irq_no, 1'b1);
    chk("R1 lamp after release", fault_lamp_o, 1'b0);

    // table walk, unarmed; first strobe sets the reference
    pulse(1'b0);
    for (int i = 0; i < VN; i++) begin
      gap_pulse(VGAP[i], 1'b0);
      if (VGAP[i] == EARLY || VGAP[i] == LATE || VGAP[i] == LATE - 1)
        chk($sformatf("R5 gap %0d", VGAP[i]), wdt_irq_no, VEXP[i]);
      else if (VGAP[i] < EARLY)
        chk($sformatf("R3 gap %0d", VGAP[i]), wdt_irq_no, VEXP[i]);
      else if (VGAP[i] >= LATE)
        chk($sformatf("R4 gap %0d", VGAP[i]), wdt_irq_no, VEXP[i]);
      else
        chk($sformatf("R6 gap %0d", VGAP[i]), wdt_irq_no, VEXP[i]);
      chk("R7 lamp off unarmed", fault_lamp_o, 1'b0);
    end

    // timeout edge exactness
    repeat (LATE - 1) @(negedge clk_i);
    chk("R4 irq high one cycle before limit", wdt_irq_no, 1'b1);
    @(negedge clk_i);
    chk("R4 irq low at limit", wdt_irq_no, 1'b0);
    chk("R7 no latch on unarmed timeout", fault_lamp_o, 1'b0);
    pulse(1'b0);

    // arm level without strobe does nothing
    arm_i = 1'b1;
    repeat (5) @(negedge clk_i);
    arm_i = 1'b0;
    gap_pulse(40, 1'b0);
    chk("R8 arm without strobe ignored, early irq", wdt_irq_no, 1'b0);
    chk("R8 arm without strobe ignored, lamp", fault_lamp_o, 1'b0);
    gap_pulse(100, 1'b0);
    chk("R7 release after on-time strobe", wdt_irq_no, 1'b1);

    // arming strobe is not judged (early gap)
    gap_pulse(30, 1'b1);
    chk("R8 arming strobe irq", wdt_irq_no, 1'b1);
    chk("R8 arming strobe lamp", fault_lamp_o, 1'b0);
    gap_pulse(100, 1'b0);
    chk("R6 armed on-time", wdt_irq_no, 1'b1);
    gap_pulse(110, 1'b0);
    chk("R6 armed on-time 2", drive_inhibit_no, 1'b1);

    // armed early violation latches
    gap_pulse(50, 1'b0);
    chk("R9 early lock irq", wdt_irq_no, 1'b0);
    chk("R9 early lock lamp", fault_lamp_o, 1'b1);
    chk("R9 early lock inhibit", drive_inhibit_no, 1'b0);
    gap_pulse(100, 1'b0);
    chk("R10 strobe ignored irq", wdt_irq_no, 1'b0);
    chk("R10 strobe ignored lamp", fault_lamp_o, 1'b1);
    repeat (300) @(negedge clk_i);
    chk("R10 idle stays locked", wdt_irq_no, 1'b0);
    gap_pulse(100, 1'b1);
    chk("R10 arm strobe ignored", fault_lamp_o, 1'b1);

    // power-on reset releases and disarms
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R11 reset releases irq", wdt_irq_no, 1'b1);
    chk("R11 reset releases lamp", fault_lamp_o, 1'b0);
    chk("R11 reset releases inhibit", drive_inhibit_no, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    pulse(1'b0);
    gap_pulse(40, 1'b0);
    chk("R11 disarmed after reset irq", wdt_irq_no, 1'b0);
    chk("R11 disarmed after reset lamp", fault_lamp_o, 1'b0);
    gap_pulse(100, 1'b0);
    chk("R7 release after reset", wdt_irq_no, 1'b1);

    // armed timeout latches
    gap_pulse(100, 1'b1);
    chk("R8 re-arm irq", wdt_irq_no, 1'b1);
    repeat (LATE + 10) @(negedge clk_i);
    chk("R9 timeout lock irq", wdt_irq_no, 1'b0);
    chk("R9 timeout lock lamp", fault_lamp_o, 1'b1);
    chk("R9 timeout lock inhibit", drive_inhibit_no, 1'b0);
    pulse(1'b0);
    chk("R10 strobe after timeout lock", fault_lamp_o, 1'b1);
    chk("R10 irq after timeout lock", wdt_irq_no, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule